// File: doc/BRIEF.md
# SMBus Master SCL Clock Generator

This block produces the SCL waveform for a two-wire bus master. It does not divide the system clock. Its phase lengths are counted in overflow pulses from a timer chosen out of four shared sources by a 2-bit select. A low phase is two overflows long and a high phase is one, so on an unloaded bus the bit rate is the overflow rate divided by three. Each phase also waits on the sampled bus level. A slave that holds SCL low lengthens the cycle, and a master that pulls SCL low during the high phase forces a fresh low phase.

The surrounding master controller raises `master_req` while it owns the bus and counts `bit_tick` pulses, one for each finished SCL period. START and STOP framing, data shifting, arbitration and slave behaviour are handled elsewhere.

Top module: `smb_scl_gen`

## Requirements
- R1: Strobe lane k of `ovf_strobe` belongs to select code k: code 0 is the timer-1 overflow, code 1 the timer-2 high-byte overflow, code 2 the timer-2 low-byte overflow and code 3 the timer-0 overflow. Only the lane of the latched code advances a phase count.
- R2: With `enable` and `master_req` high, `scl_pull_low` goes high on the first clock edge. It stays high until the edge that samples the LOW_OVF-th (default 2) selected strobe, and on that edge it drops.
- R3: After SCL is released, the high phase does not begin until the synchronized `scl_in` is seen high. The synchronizer has two flops, so this happens on the third edge after the line rises. Strobes that arrive before then are not counted.
- R4: The high phase ends on the edge that samples the HIGH_OVF-th (default 1) selected strobe. On that edge `bit_tick` goes high for exactly one cycle and `scl_pull_low` goes high again.
- R5: If the synchronized SCL is low during the high phase, `scl_pull_low` is asserted and a new low phase starts with its count at zero. It then needs the full LOW_OVF strobes.
- R6: A new `src_sel` value is taken only at the start of a low phase. A change made in the middle of a phase neither ends nor lengthens that phase.
- R7: When `enable` is low, `scl_pull_low` is low on the next edge and stays low, `bit_tick` stays low, and strobes have no effect.
- R8: When `master_req` falls, the block releases SCL on the next edge and returns to idle. In idle, strobes produce no pull and no tick.
- R9: While another device holds SCL low after the release, the block keeps SCL released and waits for as long as that lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| src_sel | input | 2 | Overflow source select code |
| ovf_strobe | input | 4 | Single-cycle overflow pulses, lane k belongs to code k |
| master_req | input | 1 | Master owns the bus |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | Drives SCL low through the open-drain stage when high |
| bit_tick | output | 1 | One-cycle pulse at the end of each SCL period |

## Verification
A strobe driven at a falling edge is taken on the next rising edge. The pull output and `bit_tick` change on that same edge, so the bench checks them at the following falling edge. A change on the bus line reaches the phase logic only on the third rising edge, because it passes through two synchronizer flops and the state register. The contention and release checks therefore look both at the second falling edge, where the old value must still show, and at the third, where the new one must. Cases where a strobe should be ignored are checked by confirming at the ports that neither the pull nor the tick moved, and then that the exact count of correct strobes is still needed.

// File: rtl/smb_scl_pkg.sv
package smb_scl_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_t;
endpackage

// File: rtl/smb_scl_src_sel.sv
module smb_scl_src_sel #(
   parameter int SEL_W = 2,
   localparam int NSRC = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [NSRC-1:0]  strobes,
   output logic             pulse
);
   logic [SEL_W-1:0] sel_q;
   logic [NSRC-1:0]  hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_q <= '0;
      else if (load) sel_q <= sel_in;
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_lane
      assign hit[k] = strobes[k] && (sel_q == SEL_W'(k));
   end

   assign pulse = |hit;

   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R1
endmodule

// File: rtl/smb_scl_sync.sv
module smb_scl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b1;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b1;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/smb_scl_phase.sv
module smb_scl_phase
   import smb_scl_pkg::*;
#(
   parameter int LOW_OVF  = 2,
   parameter int HIGH_OVF = 1,
   localparam int MAXC  = (LOW_OVF > HIGH_OVF) ? LOW_OVF : HIGH_OVF,
   localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic ovf,
   input  logic line_hi,
   output logic load_sel,
   output logic pull_low,
   output logic tick
);
   localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_OVF - 1);
   localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_OVF - 1);

   phase_t           st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             tick_n;

   always_comb begin
      st_n     = st;
      cnt_n    = cnt;
      tick_n   = 1'b0;
      load_sel = 1'b0;
      if (!go) begin
         st_n  = PH_IDLE;
         cnt_n = '0;
      end else begin
         case (st)
            PH_IDLE: begin
               st_n     = PH_LOW;
               cnt_n    = '0;
               load_sel = 1'b1;
            end
            PH_LOW: begin
               if (ovf) begin
                  if (cnt == LOW_LAST) begin
                     st_n  = PH_WAIT;
                     cnt_n = '0;
                  end else begin
                     cnt_n = cnt + 1'b1;
                  end
               end
            end
            PH_WAIT: begin
               if (line_hi) begin
                  st_n  = PH_HIGH;
                  cnt_n = '0;
               end
            end
            PH_HIGH: begin
               if (!line_hi) begin
                  st_n     = PH_LOW;
                  cnt_n    = '0;
                  load_sel = 1'b1;
               end else if (ovf) begin
                  if (cnt == HIGH_LAST) begin
                     st_n     = PH_LOW;
                     cnt_n    = '0;
                     tick_n   = 1'b1;
                     load_sel = 1'b1;
                  end else begin
                     cnt_n = cnt + 1'b1;
                  end
               end
            end
            default: st_n = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PH_IDLE;
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         st   <= st_n;
         cnt  <= cnt_n;
         tick <= tick_n;
      end
   end

   assign pull_low = (st == PH_LOW);

   AST_LOW_ENDS_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull_low) && $past(go) |-> $past(ovf)); // R2
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R4
   AST_TICK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(!pull_low) && $past(line_hi)); // R3
   AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !tick); // R8
endmodule

// File: rtl/smb_scl_gen.sv
module smb_scl_gen #(
   parameter int SEL_W       = 2,
   parameter int LOW_OVF     = 2,
   parameter int HIGH_OVF    = 1,
   parameter int SYNC_STAGES = 2,
   localparam int NSRC = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [NSRC-1:0]  ovf_strobe,
   input  logic             master_req,
   input  logic             scl_in,
   output logic             scl_pull_low,
   output logic             bit_tick
);
   if (LOW_OVF < 1) begin : g_bad_low
      $error("LOW_OVF must be at least 1");
   end
   if (HIGH_OVF < 1) begin : g_bad_high
      $error("HIGH_OVF must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic go, load_sel, sel_pulse, line_hi;

   assign go = enable && master_req;

   smb_scl_src_sel #(.SEL_W(SEL_W)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_sel),
      .sel_in  (src_sel),
      .strobes (ovf_strobe),
      .pulse   (sel_pulse)
   );

   smb_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (scl_in),
      .dout  (line_hi)
   );

   smb_scl_phase #(.LOW_OVF(LOW_OVF), .HIGH_OVF(HIGH_OVF)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .ovf      (sel_pulse),
      .line_hi  (line_hi),
      .load_sel (load_sel),
      .pull_low (scl_pull_low),
      .tick     (bit_tick)
   );

   AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !scl_pull_low && !bit_tick); // R7
   AST_REQ_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !master_req |=> !scl_pull_low); // R8
endmodule

// File: tb/smb_scl_gen_bench.sv
`timescale 1ns/1ps
module smb_scl_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] src_sel = 2'd0;
   logic [3:0] ovf_strobe = 4'd0;
   logic       master_req = 1'b0;
   logic       ext_low = 1'b0;
   logic       scl_in;
   logic       scl_pull_low, bit_tick;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_in = !scl_pull_low && !ext_low;

   smb_scl_gen u_smb_scl_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
      .ovf_strobe(ovf_strobe), .master_req(master_req), .scl_in(scl_in),
      .scl_pull_low(scl_pull_low), .bit_tick(bit_tick)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic pulse(input int lane);
      ovf_strobe[lane] = 1'b1;
      @(negedge clk);
      ovf_strobe = 4'd0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start(input logic [1:0] sel);
      src_sel = sel; enable = 1'b1; master_req = 1'b1;
      @(negedge clk);
   endtask

   task automatic stop_all();
      master_req = 1'b0; @(negedge clk); idle(3);
   endtask

   task automatic t_reset();
      chk("R7 reset pull", scl_pull_low, 1'b0);
      chk("R7 reset tick", bit_tick, 1'b0);
   endtask

   task automatic t_select_map();
      for (int k = 0; k < 4; k++) begin
         start(2'(k));
         chk("R2 pull after start", scl_pull_low, 1'b1);
         for (int j = 0; j < 4; j++) if (j != k) pulse(j);
         chk("R1 other lanes ignored", scl_pull_low, 1'b1);
         pulse(k);
         chk("R2 one strobe not enough", scl_pull_low, 1'b1);
         pulse(k);
         chk("R1 R2 release on second strobe", scl_pull_low, 1'b0);
         stop_all();
      end
   endtask

   task automatic t_full_period();
      start(2'd0);
      pulse(0); pulse(0);
      ext_low = 1'b1;
      pulse(0);
      idle(5);
      chk("R9 still released while stretched", scl_pull_low, 1'b0);
      chk("R3 no tick while stretched", bit_tick, 1'b0);
      ext_low = 1'b0;
      idle(2);
      pulse(0);
      chk("R3 strobe before sync ignored", bit_tick, 1'b0);
      chk("R3 still released", scl_pull_low, 1'b0);
      idle(2);
      pulse(0);
      chk("R4 tick at high end", bit_tick, 1'b1);
      chk("R4 pull again at high end", scl_pull_low, 1'b1);
      @(negedge clk);
      chk("R4 tick one cycle", bit_tick, 1'b0);
      stop_all();
   endtask

   task automatic t_contention();
      start(2'd1);
      pulse(1); pulse(1);
      idle(4);
      ext_low = 1'b1;
      idle(2);
      chk("R5 not yet seen low", scl_pull_low, 1'b0);
      idle(1);
      chk("R5 contention restarts low", scl_pull_low, 1'b1);
      ext_low = 1'b0;
      pulse(1);
      chk("R5 low count restarted", scl_pull_low, 1'b1);
      chk("R5 no tick on contention", bit_tick, 1'b0);
      pulse(1);
      chk("R5 release after full low", scl_pull_low, 1'b0);
      stop_all();
   endtask

   task automatic t_sel_change();
      start(2'd0);
      src_sel = 2'd2;
      pulse(2);
      chk("R6 new lane ignored mid-phase", scl_pull_low, 1'b1);
      pulse(0); pulse(0);
      chk("R6 old lane ends phase", scl_pull_low, 1'b0);
      idle(4);
      pulse(0);
      chk("R6 high phase on old lane", bit_tick, 1'b1);
      pulse(0); pulse(0);
      chk("R6 old lane ignored after reload", scl_pull_low, 1'b1);
      pulse(2); pulse(2);
      chk("R6 new lane active after reload", scl_pull_low, 1'b0);
      stop_all();
   endtask

   task automatic t_off();
      start(2'd3);
      enable = 1'b0;
      @(negedge clk);
      chk("R7 disable releases", scl_pull_low, 1'b0);
      for (int i = 0; i < 4; i++) begin
         pulse(3);
         chk("R7 strobes no pull", scl_pull_low, 1'b0);
         chk("R7 strobes no tick", bit_tick, 1'b0);
      end
      enable = 1'b1; master_req = 1'b0;
      pulse(3); pulse(3);
      chk("R8 idle no pull", scl_pull_low, 1'b0);
      chk("R8 idle no tick", bit_tick, 1'b0);
      master_req = 1'b1;
      @(negedge clk);
      pulse(3);
      master_req = 1'b0;
      @(negedge clk);
      chk("R8 req drop releases", scl_pull_low, 1'b0);
      idle(2);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select_map();
      t_full_period();
      t_contention();
      t_sel_change();
      t_off();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule